// File: doc/BRIEF.md
# Dual-Half Programmable Timer

This block is a timer peripheral with two 32-bit counting halves, called the low half and the high half. Each half has its own counter register and its own period register. Software reaches all of them through a 32-bit register bus with a combinational read port and a single-cycle write strobe. Counting advances only on cycles where the `tick` input is high. `tick` is the block's one internal clock-enable.

A global register holds a release bit for each half and a mode field. The mode field joins the halves into one 64-bit counter, runs them as two independent 32-bit counters, or chains them so the high half counts events of the low half. A control register holds a 2-bit enable mode for each half, which selects disabled, one-shot or periodic counting. The usual setup for a free-running time base is as follows: hold both halves in reset, pick the mode, release both halves, then put a half in periodic mode with a period of all ones and read its counter back.

Top module: `dual_half_timer`

## Requirements
- R1: After reset, the identity register at offset 0x00 reads the parameter `ID_VALUE`. The counters (0x10 low, 0x14 high), the control register (0x20) and the global register (0x24) read zero. Unused offsets read zero.
- R2: The period registers (0x18 low, 0x1C high) read back what was written. The control register reads back only its two enable fields: low at bits 7:6 and high at bits 23:22. All other bits read zero.
- R3: While a half's release bit in the global register is 0 (bit 0 low, bit 1 high), its counter reads zero. That half ignores both ticks and counter writes.
- R4: In periodic mode (enable code 2), a counter increments by one on each tick. On a tick where it equals its period, it returns to zero. It never changes without a tick or a write.
- R5: In one-shot mode (enable code 1), a counter that equals its period on a tick stays at that value, and its enable field becomes 0.
- R6: With global mode 0 or 2 (bits 3:2), the halves form one 64-bit counter. The high half increments when the low half passes from all ones to zero. Both halves follow the low half's enable field, and the 64-bit count is compared with the 64-bit period.
- R7: With global mode 1, the two halves count independently, each with its own period and enable field.
- R8: With global mode 3, the high half advances once for every tick on which the low half reaches its period. The high half uses its own enable field and its own period.
- R9: A write to the global mode field takes effect only if both release bits were 0 before the write. Release bits are always writable.
- R10: A counter write wins over a tick in the same cycle. A control write wins over the one-shot clearing of an enable field in the same cycle.
- R11: A released half with enable code 0 or 3 holds its count, and its counter can be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable; counters advance only when high |
| wrEn | input | 1 | Register write strobe |
| addr | input | AW | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |

## Verification
Two pairs of functions can land in the same cycle. The first is a software counter write and a tick. The second is a control write and the one-shot completion that clears an enable field. The bench provokes each pair by raising `wrEn` and `tick` on the same clock edge: once while a periodic count runs, and once on the exact tick where a one-shot counter sits at its period. The counter must hold the written value, the control register must hold the newly written enable code, and the next tick must then follow the new mode.

// File: rtl/dht_pkg.sv
package dht_pkg;

  // Register byte offsets
  localparam int OFS_ID     = 'h00;
  localparam int OFS_CNT_LO = 'h10;
  localparam int OFS_CNT_HI = 'h14;
  localparam int OFS_PER_LO = 'h18;
  localparam int OFS_PER_HI = 'h1C;
  localparam int OFS_CTL    = 'h20;
  localparam int OFS_GLB    = 'h24;

  // Enable field positions inside the control register
  localparam int EN_LO_LSB = 6;
  localparam int EN_HI_LSB = 22;

  // Global register layout
  localparam int GLB_REL_LSB  = 0;
  localparam int GLB_MODE_LSB = 2;

  localparam int NUM_HALVES = 2;
  localparam int LO = 0;
  localparam int HI = 1;

  typedef enum logic [1:0] {
    EN_OFF   = 2'd0,
    EN_ONCE  = 2'd1,
    EN_CYCLE = 2'd2,
    EN_RSVD  = 2'd3
  } enMode_e;

  typedef enum logic [1:0] {
    TM_WIDE     = 2'd0,
    TM_SPLIT    = 2'd1,
    TM_WIDE_ALT = 2'd2,
    TM_CHAIN    = 2'd3
  } timMode_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_ZERO = 2'd2
  } halfAct_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_HALVES-1:0] ldCnt;
    logic [NUM_HALVES-1:0] ldPer;
    halfAct_e [NUM_HALVES-1:0] act;
  } dpStrobe_t;

endpackage

// File: rtl/dht_datapath.sv
module dht_datapath
  import dht_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  dpStrobe_t                     strobe,
  input  logic [DW-1:0]                 wdata,
  output logic [NUM_HALVES-1:0][DW-1:0] cnt,
  output logic [NUM_HALVES-1:0][DW-1:0] per,
  output logic [NUM_HALVES-1:0]         match,
  output logic                          loAllOnes
);

  localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    logic [DW-1:0] cntQ;
    logic [DW-1:0] perQ;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cntQ <= '0;
      end else if (strobe.ldCnt[g]) begin
        cntQ <= wdata;
      end else begin
        unique case (strobe.act[g])
          ACT_INC:  cntQ <= cntQ + 1'b1;
          ACT_ZERO: cntQ <= '0;
          default:  cntQ <= cntQ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        perQ <= '0;
      end else if (strobe.ldPer[g]) begin
        perQ <= wdata;
      end
    end

    assign cnt[g]   = cntQ;
    assign per[g]   = perQ;
    assign match[g] = (cntQ == perQ);
  end

  assign loAllOnes = (cnt[LO] == ALL_ONES);

endmodule

// File: rtl/dht_ctrl.sv
module dht_ctrl
  import dht_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          AW       = 6,
  parameter logic [31:0] ID_VALUE = 32'h5A17_0C02
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          wrEn,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  input  logic [NUM_HALVES-1:0][DW-1:0] cnt,
  input  logic [NUM_HALVES-1:0][DW-1:0] per,
  input  logic [NUM_HALVES-1:0]         match,
  input  logic                          loAllOnes,
  output dpStrobe_t                     strobe,
  output logic [DW-1:0]                 rdata,
  output logic [NUM_HALVES-1:0]         rel,
  output timMode_e                      tmode,
  output enMode_e                       modeLo,
  output enMode_e                       modeHi
);

  enMode_e                 modeQ [NUM_HALVES];
  logic [NUM_HALVES-1:0]   relQ;
  timMode_e                tmodeQ;

  // Address decode
  logic selCntLo, selCntHi, selPerLo, selPerHi, selCtl, selGlb, selId;
  assign selId    = (addr == AW'(OFS_ID));
  assign selCntLo = (addr == AW'(OFS_CNT_LO));
  assign selCntHi = (addr == AW'(OFS_CNT_HI));
  assign selPerLo = (addr == AW'(OFS_PER_LO));
  assign selPerHi = (addr == AW'(OFS_PER_HI));
  assign selCtl   = (addr == AW'(OFS_CTL));
  assign selGlb   = (addr == AW'(OFS_GLB));

  function automatic logic isRunning(enMode_e m);
    return (m == EN_ONCE) || (m == EN_CYCLE);
  endfunction

  // Tick qualification and per-half actions
  logic     wide;
  logic     runLo;
  logic     hitLo;
  logic     loEvent;
  logic     hiTick;
  logic     runHi;
  logic     doneLo;
  logic     doneHi;
  halfAct_e actLo;
  halfAct_e actHi;

  assign wide    = (tmodeQ == TM_WIDE) || (tmodeQ == TM_WIDE_ALT);
  assign runLo   = tick && relQ[LO] && isRunning(modeQ[LO]);
  assign hitLo   = wide ? (match[LO] && match[HI]) : match[LO];
  assign loEvent = runLo && match[LO];
  assign hiTick  = (tmodeQ == TM_CHAIN) ? loEvent : tick;
  assign runHi   = hiTick && relQ[HI] && isRunning(modeQ[HI]);

  always_comb begin
    actLo  = ACT_HOLD;
    doneLo = 1'b0;
    if (!relQ[LO]) begin
      actLo = ACT_ZERO;
    end else if (runLo) begin
      if (hitLo) begin
        if (modeQ[LO] == EN_CYCLE) begin
          actLo = ACT_ZERO;
        end else begin
          doneLo = 1'b1;
        end
      end else begin
        actLo = ACT_INC;
      end
    end
  end

  always_comb begin
    actHi  = ACT_HOLD;
    doneHi = 1'b0;
    if (!relQ[HI]) begin
      actHi = ACT_ZERO;
    end else if (wide) begin
      if (runLo) begin
        if (hitLo) begin
          actHi = (modeQ[LO] == EN_CYCLE) ? ACT_ZERO : ACT_HOLD;
        end else if (loAllOnes) begin
          actHi = ACT_INC;
        end
      end
    end else if (runHi) begin
      if (match[HI]) begin
        if (modeQ[HI] == EN_CYCLE) begin
          actHi = ACT_ZERO;
        end else begin
          doneHi = 1'b1;
        end
      end else begin
        actHi = ACT_INC;
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.act[LO]    = actLo;
    strobe.act[HI]    = actHi;
    strobe.ldCnt[LO]  = wrEn && selCntLo && relQ[LO];
    strobe.ldCnt[HI]  = wrEn && selCntHi && relQ[HI];
    strobe.ldPer[LO]  = wrEn && selPerLo;
    strobe.ldPer[HI]  = wrEn && selPerHi;
  end

  // Control register: a bus write beats the one-shot clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ[LO] <= EN_OFF;
      modeQ[HI] <= EN_OFF;
    end else if (wrEn && selCtl) begin
      modeQ[LO] <= enMode_e'(wdata[EN_LO_LSB +: 2]);
      modeQ[HI] <= enMode_e'(wdata[EN_HI_LSB +: 2]);
    end else begin
      if (doneLo) modeQ[LO] <= EN_OFF;
      if (doneHi) modeQ[HI] <= EN_OFF;
    end
  end

  // Global register: mode field locked while any half is released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      relQ   <= '0;
      tmodeQ <= TM_WIDE;
    end else if (wrEn && selGlb) begin
      relQ <= wdata[GLB_REL_LSB +: NUM_HALVES];
      if (relQ == '0) begin
        tmodeQ <= timMode_e'(wdata[GLB_MODE_LSB +: 2]);
      end
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    if (selId) begin
      rdata = DW'(ID_VALUE);
    end else if (selCntLo) begin
      rdata = cnt[LO];
    end else if (selCntHi) begin
      rdata = cnt[HI];
    end else if (selPerLo) begin
      rdata = per[LO];
    end else if (selPerHi) begin
      rdata = per[HI];
    end else if (selCtl) begin
      rdata[EN_LO_LSB +: 2] = modeQ[LO];
      rdata[EN_HI_LSB +: 2] = modeQ[HI];
    end else if (selGlb) begin
      rdata[GLB_REL_LSB +: NUM_HALVES] = relQ;
      rdata[GLB_MODE_LSB +: 2]         = tmodeQ;
    end
  end

  assign rel    = relQ;
  assign tmode  = tmodeQ;
  assign modeLo = modeQ[LO];
  assign modeHi = modeQ[HI];

endmodule

// File: rtl/dual_half_timer.sv
module dual_half_timer
  import dht_pkg::*;
#(
  parameter int          AW       = 6,
  parameter logic [31:0] ID_VALUE = 32'h5A17_0C02
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  localparam int DW = 32;

  dpStrobe_t                     strobe;
  logic [NUM_HALVES-1:0][DW-1:0] cnt;
  logic [NUM_HALVES-1:0][DW-1:0] per;
  logic [NUM_HALVES-1:0]         match;
  logic                          loAllOnes;
  logic [NUM_HALVES-1:0]         rel;
  timMode_e                      tmode;
  enMode_e                       modeLo;
  enMode_e                       modeHi;
  logic [DW-1:0]                 cntLo;
  logic [DW-1:0]                 perLo;

  dht_ctrl #(
    .DW       (DW),
    .AW       (AW),
    .ID_VALUE (ID_VALUE)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wrEn      (wrEn),
    .addr      (addr),
    .wdata     (wdata),
    .cnt       (cnt),
    .per       (per),
    .match     (match),
    .loAllOnes (loAllOnes),
    .strobe    (strobe),
    .rdata     (rdata),
    .rel       (rel),
    .tmode     (tmode),
    .modeLo    (modeLo),
    .modeHi    (modeHi)
  );

  dht_datapath #(
    .DW (DW)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wdata     (wdata),
    .cnt       (cnt),
    .per       (per),
    .match     (match),
    .loAllOnes (loAllOnes)
  );

  assign cntLo = cnt[LO];
  assign perLo = per[LO];

endmodule

// File: rtl/dht_checker.sv
module dht_checker
  import dht_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wrEn,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic [1:0]    rel,
  input timMode_e      tmode,
  input enMode_e       modeLo,
  input logic [31:0]   cntLo,
  input logic [31:0]   perLo
);

  // R3
  held_lo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rel[LO] |=> (cntLo == '0));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wrEn && rel[LO]) |=> $stable(cntLo));

  // R9
  mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel != 2'b00) |=> $stable(tmode));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == AW'(OFS_CNT_LO) && rel[LO]) |=> (cntLo == $past(wdata)));

  // R5
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode == TM_SPLIT && rel[LO] && tick && modeLo == EN_ONCE &&
     cntLo == perLo && !(wrEn && addr == AW'(OFS_CTL))) |=> (modeLo == EN_OFF));

endmodule

bind dual_half_timer dht_checker #(.AW(AW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .wrEn   (wrEn),
  .addr   (addr),
  .wdata  (wdata),
  .rel    (rel),
  .tmode  (tmode),
  .modeLo (modeLo),
  .cntLo  (cntLo),
  .perLo  (perLo)
);

// File: tb/tb_dual_half_timer.sv
module tb_dual_half_timer;

  localparam int          AW    = 6;
  localparam logic [31:0] IDV   = 32'h3C5E_9A01;
  localparam int A_ID = 'h00, A_CLO = 'h10, A_CHI = 'h14, A_PLO = 'h18,
                 A_PHI = 'h1C, A_CTL = 'h20, A_GLB = 'h24, A_UNUSED = 'h28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dual_half_timer #(.AW(AW), .ID_VALUE(IDV)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(logic w, int a, logic [31:0] d, logic t);
    @(negedge clk);
    wrEn = w; addr = AW'(a); wdata = d; tick = t;
    @(posedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    drive(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 32'h0, 1'b1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 32'h0, 1'b0);
  endtask

  task automatic rdChk(string req, int a, logic [31:0] exp);
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0; addr = AW'(a);
    #1 chk(req, rdata, exp);
  endtask

  task automatic setMode(int tm);
    wr(A_GLB, 32'h0);
    wr(A_GLB, 32'(tm << 2));
    wr(A_GLB, 32'((tm << 2) | 3));
  endtask

  function automatic logic [31:0] ctlVal(logic [1:0] lo, logic [1:0] hi);
    return (32'(hi) << 22) | (32'(lo) << 6);
  endfunction

  // Independent model of one half in split mode
  function automatic void stepHalf(input bit t, input logic [31:0] p,
                                   inout logic [31:0] c, inout logic [1:0] m);
    if (t && (m == 2'd1 || m == 2'd2)) begin
      if (c == p) begin
        if (m == 2'd2) c = 32'h0;
        else m = 2'd0;
      end else begin
        c = c + 1;
      end
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rdChk("R1 id", A_ID, IDV);
    rdChk("R1 glb", A_GLB, 32'h0);
    rdChk("R1 ctl", A_CTL, 32'h0);
    rdChk("R1 clo", A_CLO, 32'h0);
    rdChk("R1 chi", A_CHI, 32'h0);
    rdChk("R1 unused", A_UNUSED, 32'h0);

    // R2 readback
    wr(A_PLO, 32'hDEAD_BEEF);
    wr(A_PHI, 32'h1234_5678);
    rdChk("R2 plo", A_PLO, 32'hDEAD_BEEF);
    rdChk("R2 phi", A_PHI, 32'h1234_5678);
    wr(A_CTL, 32'hFFFF_FFFF);
    rdChk("R2 ctl fields", A_CTL, 32'h00C0_00C0);

    // R3 halves held in reset
    wr(A_CTL, ctlVal(2, 2));
    wr(A_PLO, 32'hFFFF_FFFF);
    wr(A_CLO, 32'd5);
    rdChk("R3 write ignored", A_CLO, 32'h0);
    ticks(5);
    rdChk("R3 lo ticks ignored", A_CLO, 32'h0);
    rdChk("R3 hi ticks ignored", A_CHI, 32'h0);

    // R9 mode field lock
    wr(A_GLB, 32'h4);
    rdChk("R9 mode set in reset", A_GLB, 32'h4);
    wr(A_GLB, 32'h7);
    rdChk("R9 release", A_GLB, 32'h7);
    wr(A_GLB, 32'hF);
    rdChk("R9 locked", A_GLB, 32'h7);

    // R4 / R10 write against tick
    ticks(3);
    rdChk("R4 free run", A_CLO, 32'd3);
    drive(1'b1, A_CLO, 32'h55, 1'b1);
    rdChk("R10 write wins", A_CLO, 32'h55);
    ticks(1);
    rdChk("R10 counts on", A_CLO, 32'h56);

    // R11 disabled holds, writable
    wr(A_CTL, 32'h0);
    wr(A_CLO, 32'd100);
    ticks(4);
    rdChk("R11 off holds", A_CLO, 32'd100);
    wr(A_CTL, ctlVal(3, 0));
    ticks(2);
    rdChk("R11 code3 holds", A_CLO, 32'd100);

    // R4 periodic wrap
    wr(A_PLO, 32'd3);
    wr(A_CLO, 32'd0);
    wr(A_CTL, ctlVal(2, 0));
    ticks(3);
    rdChk("R4 at period", A_CLO, 32'd3);
    idle(2);
    rdChk("R4 no tick hold", A_CLO, 32'd3);
    ticks(1);
    rdChk("R4 wrap", A_CLO, 32'd0);
    ticks(2);
    rdChk("R4 after wrap", A_CLO, 32'd2);

    // R5 one-shot on high half
    wr(A_CTL, 32'h0);
    wr(A_PHI, 32'd2);
    wr(A_CHI, 32'd0);
    wr(A_CTL, ctlVal(0, 1));
    ticks(5);
    rdChk("R5 stop", A_CHI, 32'd2);
    rdChk("R5 clear", A_CTL, 32'h0);

    // R10 control write against one-shot completion
    wr(A_PLO, 32'd2);
    wr(A_CLO, 32'd0);
    wr(A_CTL, ctlVal(1, 0));
    ticks(2);
    rdChk("R10 at period", A_CLO, 32'd2);
    drive(1'b1, A_CTL, ctlVal(2, 0), 1'b1);
    rdChk("R10 ctl wins", A_CTL, ctlVal(2, 0));
    rdChk("R10 hold", A_CLO, 32'd2);
    ticks(1);
    rdChk("R10 new mode", A_CLO, 32'd0);

    // R7 random unchained runs
    setMode(1);
    for (int r = 0; r < 4; r++) begin
      logic [31:0] pl, ph, cl, ch;
      logic [1:0]  ml, mh;
      pl = 32'($urandom_range(0, 7));
      ph = 32'($urandom_range(0, 7));
      ml = 2'($urandom_range(1, 2));
      mh = 2'($urandom_range(1, 2));
      cl = 0; ch = 0;
      wr(A_CTL, 32'h0);
      wr(A_CLO, 32'h0);
      wr(A_CHI, 32'h0);
      wr(A_PLO, pl);
      wr(A_PHI, ph);
      wr(A_CTL, ctlVal(ml, mh));
      for (int i = 0; i < 60; i++) begin
        bit t;
        t = 1'($urandom_range(0, 1));
        drive(1'b0, 0, 32'h0, t);
        stepHalf(t, pl, cl, ml);
        stepHalf(t, ph, ch, mh);
        if (i % 10 == 9) begin
          rdChk("R7 lo", A_CLO, cl);
          rdChk("R7 hi", A_CHI, ch);
          rdChk("R7 ctl", A_CTL, ctlVal(ml, mh));
        end
      end
    end

    // R6 64-bit carry and compare
    setMode(0);
    wr(A_PLO, 32'hFFFF_FFFF);
    wr(A_PHI, 32'hFFFF_FFFF);
    wr(A_CTL, ctlVal(2, 0));
    wr(A_CLO, 32'hFFFF_FFFE);
    wr(A_CHI, 32'h0);
    ticks(1);
    rdChk("R6 lo ones", A_CLO, 32'hFFFF_FFFF);
    rdChk("R6 hi before", A_CHI, 32'h0);
    ticks(1);
    rdChk("R6 lo carry", A_CLO, 32'h0);
    rdChk("R6 hi carry", A_CHI, 32'h1);
    wr(A_PLO, 32'd2);
    wr(A_PHI, 32'd1);
    wr(A_CLO, 32'd0);
    wr(A_CHI, 32'd1);
    ticks(2);
    rdChk("R6 lo at 64 period", A_CLO, 32'd2);
    ticks(1);
    rdChk("R6 lo 64 wrap", A_CLO, 32'd0);
    rdChk("R6 hi 64 wrap", A_CHI, 32'd0);
    wr(A_CHI, 32'd1);
    wr(A_CTL, ctlVal(1, 0));
    ticks(5);
    rdChk("R6 oneshot lo", A_CLO, 32'd2);
    rdChk("R6 oneshot hi", A_CHI, 32'd1);
    rdChk("R6 oneshot clear", A_CTL, 32'h0);
    setMode(2);
    wr(A_PLO, 32'hFFFF_FFFF);
    wr(A_PHI, 32'hFFFF_FFFF);
    wr(A_CLO, 32'hFFFF_FFFF);
    wr(A_CTL, ctlVal(2, 0));
    ticks(1);
    rdChk("R6 alt carry", A_CHI, 32'h1);

    // R8 chained
    setMode(3);
    wr(A_PLO, 32'd2);
    wr(A_PHI, 32'd10);
    wr(A_CTL, ctlVal(2, 2));
    ticks(9);
    rdChk("R8 lo", A_CLO, 32'd0);
    rdChk("R8 hi", A_CHI, 32'd3);
    ticks(2);
    rdChk("R8 lo mid", A_CLO, 32'd2);
    rdChk("R8 hi mid", A_CHI, 32'd3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule